// File: doc/BRIEF.md
# Buffered Dual-Register Output Compare

This block drives a compare output pin from a pair of compare registers that take turns, so that software can load the next compare value without disturbing the waveform already in progress. It watches an external free-running counter value together with the counter's overflow strobe. It owns no counter of its own. When the link control is high, the two registers form one buffered channel on the primary pin. A new value written into the idle register waits in the background. The hand-over to that register happens only at the next overflow. At each overflow the register that was written most recently takes control.

When the link control is low, the two registers act as two independent compare channels, each with its own pin, match flag and action select. On a compare match a channel sets, clears or toggles its pin, or leaves it alone, and raises a match flag for one clock. A status output tells software which register currently drives the primary pin. Software uses it to avoid writing the active register, because such a write takes effect at once, the same as an unbuffered compare.

Top module: `bufoc_pair`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `pin0`, `pin1`, `match0`, `match1` and `active_ch` are all 0.
- R2: With `link_en` low, channel 0 compares `cnt` only against register 0 and drives `pin0` with `act0`. Channel 1 compares only against register 1 and drives `pin1` with `act1`.
- R3: Once linked, register 0 controls `pin0` until an overflow occurs after a write to register 1 (`active_ch` = 0).
- R4: A write to register 1 while register 0 is active does not change `active_ch` or the compared value until the clock edge on which `ovf` is high. From that edge, `active_ch` = 1 and register 1 is compared.
- R5: At an overflow in linked mode, the register written last since the previous overflow becomes active. A write in the overflow cycle itself counts.
- R6: An overflow with no register write since the previous overflow leaves `active_ch` unchanged.
- R7: A write to the active register changes the compared value from the next clock on, without waiting for an overflow.
- R8: The action codes are 2'b00 none, 2'b01 toggle, 2'b10 clear and 2'b11 set. When the clock edge samples `cnt` equal to the compared value, the pin applies the action at that edge and the match flag is 1 for that one cycle. The flag rises even with action none.
- R9: In linked mode, `act1` has no effect, `pin1` holds its value and `match1` stays 0.
- R10: With `link_en` low, `active_ch` is 0 and any pending hand-over is discarded. A register 1 write followed by an unlink, a relink and an overflow leaves register 0 active.
- R11: If both write strobes are high in the same cycle, register 1 counts as the last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CW | Current value of the external counter |
| ovf | input | 1 | One-cycle counter overflow strobe |
| link_en | input | 1 | High joins both registers into one buffered channel |
| act0 | input | 2 | Match action for channel 0 / linked channel |
| act1 | input | 2 | Match action for channel 1 (independent mode only) |
| wr0 | input | 1 | Write strobe for compare register 0 |
| wr1 | input | 1 | Write strobe for compare register 1 |
| wdata | input | CW | Compare value to write |
| pin0 | output | 1 | Primary compare output pin |
| pin1 | output | 1 | Channel 1 pin (independent mode) |
| match0 | output | 1 | Channel 0 match flag, one cycle |
| match1 | output | 1 | Channel 1 match flag, one cycle |
| active_ch | output | 1 | Register currently driving the primary pin |

## Verification
The properties assume that `ovf` is a one-cycle strobe sampled on the same edge as the wrapped counter value. They also assume that `link_en` changes only between clock edges, so each property can blame any change of `active_ch` on the overflow or unlink seen one edge earlier. The stimulus applies every input change on the falling edge and keeps `ovf` to isolated single cycles. It gives `cnt` arbitrary values instead of a real count, so that each match is placed on purpose and no match happens by accident. Compare values are chosen so that matches of the idle register fall on cycles where that register is not selected.

// File: rtl/bufoc_pkg.sv
package bufoc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;
endpackage

// File: rtl/bufoc_sel.sv
// Tracks which compare register drives the primary pin in linked mode.
module bufoc_sel (
  input  logic clk,
  input  logic rst,
  input  logic link_en,
  input  logic ovf,
  input  logic wr0,
  input  logic wr1,
  output logic active
);
  logic pend_v;
  logic pend_ch;
  logic wr_any;
  logic last_wr;

  assign wr_any  = wr0 | wr1;
  assign last_wr = wr1;          // register 1 wins a same-cycle tie

  always_ff @(posedge clk) begin
    if (rst || !link_en) begin
      active  <= 1'b0;
      pend_v  <= 1'b0;
      pend_ch <= 1'b0;
    end else if (ovf) begin
      if (wr_any)      active <= last_wr;
      else if (pend_v) active <= pend_ch;
      pend_v <= 1'b0;
    end else if (wr_any) begin
      pend_v  <= 1'b1;
      pend_ch <= last_wr;
    end
  end
endmodule

// File: rtl/bufoc_chan.sv
// One compare unit: equality match, registered flag and pin action.
module bufoc_chan
  import bufoc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic [1:0]    act,
  output logic          pin,
  output logic          match
);
  oc_act_e act_e;
  logic    hit;

  assign act_e = oc_act_e'(act);
  assign hit   = en && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin   <= 1'b0;
      match <= 1'b0;
    end else begin
      match <= hit;
      if (hit) begin
        unique case (act_e)
          ACT_TOGGLE: pin <= ~pin;
          ACT_CLEAR:  pin <= 1'b0;
          ACT_SET:    pin <= 1'b1;
          default:    pin <= pin;
        endcase
      end
    end
  end
endmodule

// File: rtl/bufoc_pair.sv
module bufoc_pair
  import bufoc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          ovf,
  input  logic          link_en,
  input  logic [1:0]    act0,
  input  logic [1:0]    act1,
  input  logic          wr0,
  input  logic          wr1,
  input  logic [CW-1:0] wdata,
  output logic          pin0,
  output logic          pin1,
  output logic          match0,
  output logic          match1,
  output logic          active_ch
);
  localparam int NCH = 2;

  logic [CW-1:0] cmp_q [NCH];
  logic [NCH-1:0] wr_v;
  logic [CW-1:0] cmp_use [NCH];
  logic [1:0]    act_use [NCH];
  logic [NCH-1:0] en_v;
  logic [NCH-1:0] pin_v;
  logic [NCH-1:0] match_v;

  assign wr_v = {wr1, wr0};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)          cmp_q[i] <= '0;
        else if (wr_v[i]) cmp_q[i] <= wdata;
      end
    end
  endgenerate

  bufoc_sel u_sel (
    .clk     (clk),
    .rst     (rst),
    .link_en (link_en),
    .ovf     (ovf),
    .wr0     (wr0),
    .wr1     (wr1),
    .active  (active_ch)
  );

  // Channel 0 follows the active register when linked; channel 1 sleeps.
  assign cmp_use[0] = (link_en && active_ch) ? cmp_q[1] : cmp_q[0];
  assign cmp_use[1] = cmp_q[1];
  assign act_use[0] = act0;
  assign act_use[1] = act1;
  assign en_v       = {~link_en, 1'b1};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      bufoc_chan #(.CW(CW)) u_ch (
        .clk   (clk),
        .rst   (rst),
        .en    (en_v[i]),
        .cnt   (cnt),
        .cmp   (cmp_use[i]),
        .act   (act_use[i]),
        .pin   (pin_v[i]),
        .match (match_v[i])
      );
    end
  endgenerate

  assign pin0   = pin_v[0];
  assign pin1   = pin_v[1];
  assign match0 = match_v[0];
  assign match1 = match_v[1];
endmodule

// File: rtl/bufoc_pair_chk.sv
module bufoc_pair_chk (
  input logic clk,
  input logic rst,
  input logic ovf,
  input logic link_en,
  input logic pin0,
  input logic pin1,
  input logic match0,
  input logic match1,
  input logic active_ch
);
  a_r4_switch_on_ovf: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_ch) |-> ($past(ovf) || !$past(link_en)));

  a_r10_unlink_zero: assert property (@(posedge clk) disable iff (rst)
    !link_en |=> !active_ch);

  a_r9_flag1_quiet: assert property (@(posedge clk) disable iff (rst)
    match1 |-> !$past(link_en));

  a_r9_pin1_hold: assert property (@(posedge clk) disable iff (rst)
    $past(link_en) |-> $stable(pin1));

  a_r8_pin0_needs_match: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin0) |-> match0);

  a_r8_pin1_needs_match: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin1) |-> match1);
endmodule

bind bufoc_pair bufoc_pair_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ovf       (ovf),
  .link_en   (link_en),
  .pin0      (pin0),
  .pin1      (pin1),
  .match0    (match0),
  .match1    (match1),
  .active_ch (active_ch)
);

// File: tb/bufoc_pair_bench.sv
`timescale 1ns/1ps
module bufoc_pair_bench;
  localparam int CW = 16;
  localparam logic [1:0] N = 2'b00, T = 2'b01, C = 2'b10, S = 2'b11;

  typedef struct packed {
    logic          ln;
    logic          w0;
    logic          w1;
    logic [CW-1:0] d;
    logic [CW-1:0] c;
    logic          o;
    logic [1:0]    a0;
    logic          ep;
    logic          em;
    logic          ea;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b1,1'b0,16'd10,16'd1, 1'b0,T, 1'b0,1'b0,1'b0}, // R3 load reg0
    '{1'b1,1'b0,1'b1,16'd20,16'd5, 1'b0,T, 1'b0,1'b0,1'b0}, // R4 load reg1, no switch
    '{1'b1,1'b0,1'b0,16'd0, 16'd10,1'b0,T, 1'b1,1'b1,1'b0}, // R3 reg0 still controls
    '{1'b1,1'b0,1'b0,16'd0, 16'd20,1'b0,T, 1'b1,1'b0,1'b0}, // R4 reg1 not yet compared
    '{1'b1,1'b0,1'b0,16'd0, 16'd0, 1'b1,T, 1'b1,1'b0,1'b1}, // R4 switch at overflow
    '{1'b1,1'b0,1'b0,16'd0, 16'd20,1'b0,T, 1'b0,1'b1,1'b1}, // R4 reg1 matches
    '{1'b1,1'b0,1'b0,16'd0, 16'd10,1'b0,T, 1'b0,1'b0,1'b1}, // R4 reg0 ignored
    '{1'b1,1'b0,1'b1,16'd30,16'd3, 1'b0,T, 1'b0,1'b0,1'b1}, // R7 write active reg
    '{1'b1,1'b0,1'b0,16'd0, 16'd30,1'b0,T, 1'b1,1'b1,1'b1}, // R7 new value at once
    '{1'b1,1'b0,1'b1,16'd40,16'd4, 1'b0,T, 1'b1,1'b0,1'b1}, // R5 write reg1
    '{1'b1,1'b1,1'b0,16'd50,16'd5, 1'b0,T, 1'b1,1'b0,1'b1}, // R5 then reg0
    '{1'b1,1'b0,1'b0,16'd0, 16'd0, 1'b1,T, 1'b1,1'b0,1'b0}, // R5 last written wins
    '{1'b1,1'b0,1'b0,16'd0, 16'd50,1'b0,T, 1'b0,1'b1,1'b0}, // R5 reg0 matches
    '{1'b1,1'b0,1'b0,16'd0, 16'd0, 1'b1,T, 1'b0,1'b0,1'b0}, // R6 idle overflow
    '{1'b1,1'b1,1'b1,16'd60,16'd7, 1'b0,T, 1'b0,1'b0,1'b0}, // R11 both strobes
    '{1'b1,1'b0,1'b0,16'd0, 16'd0, 1'b1,T, 1'b0,1'b0,1'b1}, // R11 reg1 taken
    '{1'b0,1'b0,1'b0,16'd0, 16'd0, 1'b0,T, 1'b0,1'b0,1'b0}, // R10 unlink clears
    '{1'b1,1'b0,1'b1,16'd70,16'd2, 1'b0,T, 1'b0,1'b0,1'b0}, // R10 pend reg1
    '{1'b0,1'b0,1'b0,16'd0, 16'd2, 1'b0,T, 1'b0,1'b0,1'b0}, // R10 unlink drops it
    '{1'b1,1'b0,1'b0,16'd0, 16'd0, 1'b1,T, 1'b0,1'b0,1'b0}, // R10 stays reg0
    '{1'b1,1'b0,1'b0,16'd0, 16'd60,1'b0,S, 1'b1,1'b1,1'b0}, // R8 set
    '{1'b1,1'b0,1'b0,16'd0, 16'd60,1'b0,C, 1'b0,1'b1,1'b0}, // R8 clear
    '{1'b1,1'b0,1'b0,16'd0, 16'd60,1'b0,N, 1'b0,1'b1,1'b0}, // R8 none, flag still
    '{1'b1,1'b0,1'b0,16'd0, 16'd61,1'b0,S, 1'b0,1'b0,1'b0}  // R8 flag one cycle
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt = 16'd1;
  logic          ovf = 1'b0;
  logic          link_en = 1'b1;
  logic [1:0]    act0 = 2'b01;
  logic [1:0]    act1 = 2'b00;
  logic          wr0 = 1'b0;
  logic          wr1 = 1'b0;
  logic [CW-1:0] wdata = '0;
  logic          pin0, pin1, match0, match1, active_ch;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bufoc_pair #(.CW(CW)) u_bufoc_pair (
    .clk(clk), .rst(rst), .cnt(cnt), .ovf(ovf), .link_en(link_en),
    .act0(act0), .act1(act1), .wr0(wr0), .wr1(wr1), .wdata(wdata),
    .pin0(pin0), .pin1(pin1), .match0(match0), .match1(match1),
    .active_ch(active_ch)
  );

  function automatic string row_req(input int r);
    case (r)
      0, 2:              return "R3";
      1, 3, 4, 5, 6:     return "R4";
      7, 8:              return "R7";
      9, 10, 11, 12:     return "R5";
      13:                return "R6";
      14, 15:            return "R11";
      16, 17, 18, 19:    return "R10";
      default:           return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic ln, input logic w0, input logic w1,
                      input logic [CW-1:0] d, input logic [CW-1:0] c,
                      input logic o, input logic [1:0] a0, input logic [1:0] a1);
    link_en = ln; wr0 = w0; wr1 = w1; wdata = d; cnt = c; ovf = o;
    act0 = a0; act1 = a1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_reset(input string req);
    chk(req, "pin0", pin0, 1'b0);
    chk(req, "pin1", pin1, 1'b0);
    chk(req, "match0", match0, 1'b0);
    chk(req, "match1", match1, 1'b0);
    chk(req, "active_ch", active_ch, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset("R1");                        // R1 during reset
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b0, '0, 16'd1, 1'b0, T, N);
    chk_reset("R1");                        // R1 first edge after reset

    for (int r = 0; r < NV; r++) begin
      step(VT[r].ln, VT[r].w0, VT[r].w1, VT[r].d, VT[r].c, VT[r].o, VT[r].a0, N);
      chk(row_req(r), $sformatf("row %0d pin0", r), pin0, VT[r].ep);
      chk(row_req(r), $sformatf("row %0d match0", r), match0, VT[r].em);
      chk(row_req(r), $sformatf("row %0d active_ch", r), active_ch, VT[r].ea);
    end

    // R2: independent channels, reg0 = 60, reg1 loaded with 100
    step(1'b0, 1'b0, 1'b1, 16'd100, 16'd5, 1'b0, T, T);
    step(1'b0, 1'b0, 1'b0, '0, 16'd100, 1'b0, T, T);
    chk("R2", "pin1 on reg1 match", pin1, 1'b1);
    chk("R2", "match1", match1, 1'b1);
    chk("R2", "pin0 untouched", pin0, 1'b0);
    chk("R2", "match0", match0, 1'b0);
    chk("R10", "active_ch unlinked", active_ch, 1'b0);
    step(1'b0, 1'b0, 1'b0, '0, 16'd60, 1'b0, T, T);
    chk("R2", "pin0 on reg0 match", pin0, 1'b1);
    chk("R2", "match1 no hit", match1, 1'b0);
    chk("R2", "pin1 holds", pin1, 1'b1);

    // R9: linked, act1 = clear would drop pin1 if it mattered
    step(1'b1, 1'b0, 1'b0, '0, 16'd100, 1'b0, T, C);
    chk("R9", "pin1 held", pin1, 1'b1);
    chk("R9", "match1 low", match1, 1'b0);
    chk("R9", "pin0 no reg1 match", pin0, 1'b1);
    chk("R9", "match0 low", match0, 1'b0);

    // R1: reset in mid-run
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b0, '0, 16'd100, 1'b0, T, N);
    chk_reset("R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule